// File: doc/BRIEF.md
# Paged Direct-Page Address Decoder

This block sits between a small 8-bit core and its memories. It takes the 8-bit direct-page address of every access and turns it into a 14-bit physical address. It then drives one chip select: scratch RAM, the index-register alias, peripheral I/O or program flash. It also returns read data from whichever source the address selects.

The top 64 bytes of direct space form a movable window. In that window the physical address takes its upper eight bits from a page register that the block holds, and its lower six bits from the address. Software writes the page register at direct address 0x1F. Through this window a program can reach flash, the second I/O block or any other part of the physical space.

Decoding is combinational, so chip selects, physical address and read data are valid in the same cycle as the request. The page register and a one-cycle out-of-range flag are the only state.

Top module: `paged_dp_decoder`

## Requirements
- R1: For a direct address below 0xC0, the physical address equals the direct address zero-extended to 14 bits.
- R2: For a direct address 0xC0 to 0xFF, physical bits [13:6] equal the page register and bits [5:0] equal direct bits [5:0]. The same region decode then applies, so page 0x00 aliases physical 0x00 to 0x3F.
- R3: Physical addresses 0x000 to 0x00E and 0x020 to 0x04F assert `cs_ram` and no other chip select.
- R4: Physical address 0x00F asserts `cs_xreg` only.
- R5: Physical addresses 0x010 to 0x01E and 0x200 to 0x23F assert `cs_io` only.
- R6: Physical address 0x01F is the page register. A write loads `wdata` at the clock edge, a read returns its value, and no chip select is asserted.
- R7: After reset the page register holds 0x80 and `oor` is low.
- R8: Flash covers the top `FLASH_BYTES` bytes of physical space, 0x3C00 to 0x3FFF by default.
  - A read there asserts `cs_flash` and returns `flash_rdata`.
  - A write there asserts no chip select and no `mem_we`, and it does not raise `oor`.
- R9: An access to any other physical address reads as zero. It raises `oor` for exactly the one cycle after the access.
- R10: A read of RAM, I/O or the index alias returns the matching `*_rdata` input. `mem_we` is high only for writes to those three targets.
- R11: While `req` is low, no chip select and no `mem_we` is asserted, and the page register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Direct-page address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the selected source |
| phys_addr | output | 14 | Physical address to the memories |
| mem_we | output | 1 | Write enable to RAM, I/O and index alias |
| cs_ram | output | 1 | RAM select |
| cs_io | output | 1 | I/O select |
| cs_xreg | output | 1 | Index-register alias select |
| cs_flash | output | 1 | Flash select (reads only) |
| ram_rdata | input | 8 | RAM read data |
| io_rdata | input | 8 | I/O read data |
| xreg_rdata | input | 8 | Index register value |
| flash_rdata | input | 8 | Flash read data |
| page_sel | output | 8 | Current page register |
| oor | output | 1 | Out-of-range pulse, one cycle after the access |

## Verification
The assertions watch, on every cycle, the properties that hold at the ports:
- at most one chip select is active;
- an idle bus selects nothing and leaves the page unchanged;
- flash is never written;
- a window access places the page register on the upper physical bits;
- a page write lands one edge later;
- every `oor` pulse follows a request that read back zero.

Only the bench scenarios can show the exact region boundaries. These include the first and last byte of each range, the gaps between ranges, and the window aliasing low space with page 0x00. The scenarios also show that data written through a chip select really comes back on a later read.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
    // physical map, used by the region decoder
    localparam int unsigned RAM0_HI    = 32'h000E;
    localparam int unsigned XALIAS_AD  = 32'h000F;
    localparam int unsigned IO0_LO     = 32'h0010;
    localparam int unsigned IO0_HI     = 32'h001E;
    localparam int unsigned PAGEREG_AD = 32'h001F;
    localparam int unsigned RAM1_LO    = 32'h0020;
    localparam int unsigned RAM1_HI    = 32'h004F;
    localparam int unsigned IO1_LO     = 32'h0200;
    localparam int unsigned IO1_HI     = 32'h023F;

    typedef enum logic [2:0] {
        RGN_NONE  = 3'd0,
        RGN_RAM   = 3'd1,
        RGN_XREG  = 3'd2,
        RGN_IO    = 3'd3,
        RGN_PAGE  = 3'd4,
        RGN_FLASH = 3'd5
    } region_e;
endpackage

// File: rtl/pdd_addr_map.sv
module pdd_addr_map #(
    parameter int DADDR_W = 8,
    parameter int PADDR_W = 14,
    parameter int WIN_W   = 6,
    localparam int PAGE_W = PADDR_W - WIN_W
) (
    input  logic [DADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0]  page,
    output logic [PADDR_W-1:0] phys
);
    logic in_window;

    // window = all address bits above the offset field set
    assign in_window = &addr[DADDR_W-1:WIN_W];

    always_comb begin
        if (in_window) begin
            phys = {page, addr[WIN_W-1:0]};
        end else begin
            phys = PADDR_W'(addr);
        end
    end
endmodule

// File: rtl/pdd_region_dec.sv
module pdd_region_dec
    import pdd_pkg::*;
#(
    parameter int PADDR_W     = 14,
    parameter int FLASH_BYTES = 1024,
    localparam int FLASH_BASE = (1 << PADDR_W) - FLASH_BYTES
) (
    input  logic [PADDR_W-1:0] phys,
    output region_e            region
);
    localparam logic [PADDR_W-1:0] A_RAM0_HI = PADDR_W'(RAM0_HI);
    localparam logic [PADDR_W-1:0] A_XALIAS  = PADDR_W'(XALIAS_AD);
    localparam logic [PADDR_W-1:0] A_IO0_LO  = PADDR_W'(IO0_LO);
    localparam logic [PADDR_W-1:0] A_IO0_HI  = PADDR_W'(IO0_HI);
    localparam logic [PADDR_W-1:0] A_PAGE    = PADDR_W'(PAGEREG_AD);
    localparam logic [PADDR_W-1:0] A_RAM1_LO = PADDR_W'(RAM1_LO);
    localparam logic [PADDR_W-1:0] A_RAM1_HI = PADDR_W'(RAM1_HI);
    localparam logic [PADDR_W-1:0] A_IO1_LO  = PADDR_W'(IO1_LO);
    localparam logic [PADDR_W-1:0] A_IO1_HI  = PADDR_W'(IO1_HI);
    localparam logic [PADDR_W-1:0] A_FLASH   = PADDR_W'(FLASH_BASE);

    always_comb begin
        region = RGN_NONE;
        if (phys <= A_RAM0_HI) begin
            region = RGN_RAM;
        end else if (phys == A_XALIAS) begin
            region = RGN_XREG;
        end else if (phys >= A_IO0_LO && phys <= A_IO0_HI) begin
            region = RGN_IO;
        end else if (phys == A_PAGE) begin
            region = RGN_PAGE;
        end else if (phys >= A_RAM1_LO && phys <= A_RAM1_HI) begin
            region = RGN_RAM;
        end else if (phys >= A_IO1_LO && phys <= A_IO1_HI) begin
            region = RGN_IO;
        end else if (phys >= A_FLASH) begin
            region = RGN_FLASH;
        end
    end
endmodule

// File: rtl/pdd_rdata_mux.sv
module pdd_rdata_mux
    import pdd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  region_e           region,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] xreg_rdata,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic [DATA_W-1:0] page_rdata,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (region)
            RGN_RAM:   rdata = ram_rdata;
            RGN_XREG:  rdata = xreg_rdata;
            RGN_IO:    rdata = io_rdata;
            RGN_PAGE:  rdata = page_rdata;
            RGN_FLASH: rdata = flash_rdata;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/paged_dp_decoder.sv
module paged_dp_decoder
    import pdd_pkg::*;
#(
    parameter int DADDR_W     = 8,
    parameter int PADDR_W     = 14,
    parameter int DATA_W      = 8,
    parameter int WIN_W       = 6,
    parameter int FLASH_BYTES = 1024,
    parameter logic [PADDR_W-WIN_W-1:0] PAGE_RESET = 8'h80,
    localparam int PAGE_W = PADDR_W - WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [DADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [PADDR_W-1:0] phys_addr,
    output logic               mem_we,
    output logic               cs_ram,
    output logic               cs_io,
    output logic               cs_xreg,
    output logic               cs_flash,
    input  logic [DATA_W-1:0]  ram_rdata,
    input  logic [DATA_W-1:0]  io_rdata,
    input  logic [DATA_W-1:0]  xreg_rdata,
    input  logic [DATA_W-1:0]  flash_rdata,
    output logic [PAGE_W-1:0]  page_sel,
    output logic               oor
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              oor;
    } state_t;

    state_t  state_d, state_q;
    region_e region;
    logic [DATA_W-1:0] page_rd;

    pdd_addr_map #(
        .DADDR_W (DADDR_W),
        .PADDR_W (PADDR_W),
        .WIN_W   (WIN_W)
    ) u_map (
        .addr (addr),
        .page (state_q.page),
        .phys (phys_addr)
    );

    pdd_region_dec #(
        .PADDR_W     (PADDR_W),
        .FLASH_BYTES (FLASH_BYTES)
    ) u_dec (
        .phys   (phys_addr),
        .region (region)
    );

    assign page_rd = DATA_W'(state_q.page);

    pdd_rdata_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .region      (region),
        .ram_rdata   (ram_rdata),
        .io_rdata    (io_rdata),
        .xreg_rdata  (xreg_rdata),
        .flash_rdata (flash_rdata),
        .page_rdata  (page_rd),
        .rdata       (rdata)
    );

    // chip selects; flash is read-only so a write selects nothing
    always_comb begin
        cs_ram   = req && (region == RGN_RAM);
        cs_io    = req && (region == RGN_IO);
        cs_xreg  = req && (region == RGN_XREG);
        cs_flash = req && !we && (region == RGN_FLASH);
        mem_we   = req && we && (region inside {RGN_RAM, RGN_IO, RGN_XREG});
    end

    always_comb begin
        state_d = state_q;
        if (req && we && region == RGN_PAGE) begin
            state_d.page = wdata[PAGE_W-1:0];
        end
        state_d.oor = req && (region == RGN_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.page <= PAGE_RESET;
            state_q.oor  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign page_sel = state_q.page;
    assign oor      = state_q.oor;
endmodule

// File: rtl/pdd_checker.sv
module pdd_checker #(
    parameter int DADDR_W = 8,
    parameter int PADDR_W = 14,
    parameter int DATA_W  = 8,
    parameter int WIN_W   = 6,
    localparam int PAGE_W = PADDR_W - WIN_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               we,
    input logic [DADDR_W-1:0] addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic [PADDR_W-1:0] phys_addr,
    input logic               mem_we,
    input logic               cs_ram,
    input logic               cs_io,
    input logic               cs_xreg,
    input logic               cs_flash,
    input logic [PAGE_W-1:0]  page_sel,
    input logic               oor
);
    localparam logic [DADDR_W-1:0] PAGE_AD = DADDR_W'(32'h1F);

    p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_ram, cs_io, cs_xreg, cs_flash}));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !(cs_ram || cs_io || cs_xreg || cs_flash || mem_we));

    p_idle_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(page_sel));

    p_flash_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_flash |-> (!we && !mem_we));

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (&addr[DADDR_W-1:WIN_W])) |->
            (phys_addr[PADDR_W-1:WIN_W] == page_sel &&
             phys_addr[WIN_W-1:0] == addr[WIN_W-1:0]));

    p_page_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == PAGE_AD) |=> (page_sel == $past(wdata[PAGE_W-1:0])));

    p_oor_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oor |-> ($past(req) && $past(rdata) == '0));
endmodule

bind paged_dp_decoder pdd_checker #(
    .DADDR_W (DADDR_W),
    .PADDR_W (PADDR_W),
    .DATA_W  (DATA_W),
    .WIN_W   (WIN_W)
) u_pdd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .phys_addr (phys_addr),
    .mem_we    (mem_we),
    .cs_ram    (cs_ram),
    .cs_io     (cs_io),
    .cs_xreg   (cs_xreg),
    .cs_flash  (cs_flash),
    .page_sel  (page_sel),
    .oor       (oor)
);

// File: tb/tb_paged_dp_decoder.sv
module tb_paged_dp_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [13:0] phys_addr;
    logic        mem_we, cs_ram, cs_io, cs_xreg, cs_flash;
    logic [7:0]  ram_rdata, io_rdata, xreg_rdata, flash_rdata;
    logic [7:0]  page_sel;
    logic        oor;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    paged_dp_decoder dut (
        .clk (clk), .rst_n (rst_n), .req (req), .we (we), .addr (addr),
        .wdata (wdata), .rdata (rdata), .phys_addr (phys_addr),
        .mem_we (mem_we), .cs_ram (cs_ram), .cs_io (cs_io),
        .cs_xreg (cs_xreg), .cs_flash (cs_flash), .ram_rdata (ram_rdata),
        .io_rdata (io_rdata), .xreg_rdata (xreg_rdata),
        .flash_rdata (flash_rdata), .page_sel (page_sel), .oor (oor)
    );

    // memory models
    logic [7:0] ram_mem [0:255];
    logic [7:0] io_mem  [0:127];
    logic [7:0] x_reg;

    always @(posedge clk) begin
        if (cs_ram && mem_we)  ram_mem[phys_addr[7:0]] <= wdata;
        if (cs_io && mem_we)   io_mem[{phys_addr[9], phys_addr[5:0]}] <= wdata;
        if (cs_xreg && mem_we) x_reg <= wdata;
    end
    assign ram_rdata   = ram_mem[phys_addr[7:0]];
    assign io_rdata    = io_mem[{phys_addr[9], phys_addr[5:0]}];
    assign xreg_rdata  = x_reg;
    assign flash_rdata = phys_addr[7:0] ^ {2'b00, phys_addr[13:8]};

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // drive at falling edge, return 5 ns later (before the rising edge)
    task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #5;
    endtask

    task automatic idle(input logic [7:0] a, input bit w, input logic [7:0] d);
        @(negedge clk);
        req = 1'b0; we = w; addr = a; wdata = d;
        #5;
    endtask

    typedef struct packed {
        logic [7:0]  page;
        logic [7:0]  addr;
        logic [3:0]  cs;     // {ram, io, xreg, flash}
        logic [13:0] phys;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{8'h00, 8'h00, 4'b1000, 14'h0000},
        '{8'h00, 8'h0E, 4'b1000, 14'h000E},
        '{8'h00, 8'h0F, 4'b0010, 14'h000F},
        '{8'h00, 8'h10, 4'b0100, 14'h0010},
        '{8'h00, 8'h1E, 4'b0100, 14'h001E},
        '{8'h00, 8'h20, 4'b1000, 14'h0020},
        '{8'h00, 8'h4F, 4'b1000, 14'h004F},
        '{8'h00, 8'h50, 4'b0000, 14'h0050},
        '{8'h00, 8'hBF, 4'b0000, 14'h00BF},
        '{8'h00, 8'hC3, 4'b1000, 14'h0003},
        '{8'hF0, 8'hC0, 4'b0001, 14'h3C00},
        '{8'hFF, 8'hFF, 4'b0001, 14'h3FFF},
        '{8'hEF, 8'hFF, 4'b0000, 14'h3BFF},
        '{8'h08, 8'hC5, 4'b0100, 14'h0205},
        '{8'h09, 8'hC0, 4'b0000, 14'h0240},
        '{8'h80, 8'hC0, 4'b0000, 14'h2000}
    };

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R7 reset state
        check(page_sel == 8'h80, "R7 page reset", page_sel, 8'h80);
        check(oor == 1'b0, "R7 oor reset", oor, 0);

        // vector table: R1 R2 R3 R4 R5 R8 decode and physical address
        foreach (VECS[i]) begin
            access(1'b1, 8'h1F, VECS[i].page);
            access(1'b0, VECS[i].addr, 8'h00);
            check({cs_ram, cs_io, cs_xreg, cs_flash} == VECS[i].cs &&
                  phys_addr == VECS[i].phys,
                  $sformatf("R1 R2 decode vec %0d (cs/phys)", i),
                  {cs_ram, cs_io, cs_xreg, cs_flash, 2'b00, phys_addr},
                  {VECS[i].cs, 2'b00, VECS[i].phys});
        end

        // R10 RAM write then read back, R3 select
        access(1'b0, 8'h1F, 8'h00);
        access(1'b1, 8'h1F, 8'h00);
        access(1'b1, 8'h05, 8'h3C);
        check(cs_ram && mem_we, "R3 ram write select", {cs_ram, mem_we}, 3);
        access(1'b0, 8'h05, 8'h00);
        check(rdata == 8'h3C, "R10 ram readback", rdata, 8'h3C);
        // R2 window alias of low RAM with page 0
        access(1'b0, 8'hC5, 8'h00);
        check(rdata == 8'h3C && cs_ram, "R2 window alias ram", rdata, 8'h3C);

        // R4 index alias
        access(1'b1, 8'h0F, 8'h9A);
        check(cs_xreg && mem_we, "R4 xreg write select", {cs_xreg, mem_we}, 3);
        access(1'b0, 8'h0F, 8'h00);
        check(rdata == 8'h9A, "R4 xreg read", rdata, 8'h9A);

        // R5 upper I/O block through the window
        access(1'b1, 8'h1F, 8'h08);
        access(1'b1, 8'hE1, 8'h47);
        check(cs_io && mem_we && phys_addr == 14'h0221, "R5 io write", phys_addr, 14'h0221);
        access(1'b0, 8'hE1, 8'h00);
        check(rdata == 8'h47, "R5 io readback", rdata, 8'h47);

        // R6 page register read back
        access(1'b0, 8'h1F, 8'h00);
        check(rdata == 8'h08, "R6 page read", rdata, 8'h08);
        check(!(cs_ram || cs_io || cs_xreg || cs_flash), "R6 no select on page reg",
              {cs_ram, cs_io, cs_xreg, cs_flash}, 0);

        // R8 flash read and dropped write
        access(1'b1, 8'h1F, 8'hF0);
        access(1'b0, 8'hC1, 8'h00);
        check(cs_flash && rdata == 8'h3D, "R8 flash read", rdata, 8'h3D);
        access(1'b1, 8'hC1, 8'h77);
        check(!(cs_ram || cs_io || cs_xreg || cs_flash) && !mem_we, "R8 flash write dropped",
              {cs_ram, cs_io, cs_xreg, cs_flash, mem_we}, 0);
        idle(8'h00, 1'b0, 8'h00);
        check(oor == 1'b0, "R8 flash write no oor", oor, 0);

        // R9 unmapped read and one-cycle flag
        access(1'b0, 8'h60, 8'h00);
        check(rdata == 8'h00, "R9 unmapped reads zero", rdata, 0);
        check(oor == 1'b0, "R9 oor not early", oor, 0);
        idle(8'h00, 1'b0, 8'h00);
        check(oor == 1'b1, "R9 oor pulse", oor, 1);
        idle(8'h00, 1'b0, 8'h00);
        check(oor == 1'b0, "R9 oor one cycle", oor, 0);

        // R10 mem_we not on reads
        access(1'b0, 8'h22, 8'h00);
        check(cs_ram && !mem_we, "R10 no write on read", mem_we, 0);

        // R11 idle bus ignores a page write and selects nothing
        idle(8'h1F, 1'b1, 8'h55);
        check(!(cs_ram || cs_io || cs_xreg || cs_flash || mem_we), "R11 idle no select",
              {cs_ram, cs_io, cs_xreg, cs_flash, mem_we}, 0);
        idle(8'h05, 1'b1, 8'h11);
        check(page_sel == 8'hF0, "R11 page held", page_sel, 8'hF0);
        access(1'b0, 8'h05, 8'h00);
        check(rdata == 8'h3C, "R11 ram untouched", rdata, 8'h3C);

        // R7 reset again restores the page
        @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check(page_sel == 8'h80, "R7 page after reset", page_sel, 8'h80);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule